// File: doc/BRIEF.md
# Power Shut-Off Sequencer

This controller runs on a slow, always-on clock and moves a switchable power domain through a complete shut-off and wake-up cycle. It drives five domain controls: a clock enable, an isolation enable, a retention save/restore level, a power-switch off command and an active-low domain reset. Each control edge is separated from the previous one by a fixed number of controller cycles, and every gap is set by a parameter. Two request inputs start the work. `sleep_req` asks for shut-off. `wake_req` asks for power to come back.

A shut-off cycle only pays back its own energy cost when the domain stays idle long enough. For that reason, entry starts only after `sleep_req` has been held for a qualifying idle count. Once entry starts, it always runs to the off state and is never aborted. A wake request that arrives during entry is latched and acted on after the minimum off time. The domain reset is pulsed while the domain clock is still gated, so the domain is expected to use an asynchronous reset.

The state machine has eleven states. `ST_ON` leaves for `ST_GATE` when the idle check passes. The entry chain is `ST_GATE` → `ST_ISO` → `ST_SAVE` → `ST_OFF`. `ST_OFF` leaves for `ST_SETTLE` once the off time has elapsed and a wake is pending. The exit chain is `ST_SETTLE` → `ST_RST_LEAD` → `ST_RST` → `ST_RST_REL` → `ST_UNSAVE` → `ST_UNISO` → `ST_ON`. Every transition except the two request-gated ones fires when that state's gap timer expires. The controls change on the same edge as the state register.

Top module: `pso_sequencer`

## Requirements
- R1: While the controller reset `rst_n` is low, and right after it is released, the outputs are dom_clk_en=1, dom_iso=0, dom_save=0, dom_pwr_off=0, dom_rst_n=1, busy=0 and pstate=0.
- R2: Entry starts only if `sleep_req` was sampled high on IDLE_HOLD consecutive rising edges while ON and is still high on the next edge. On that edge dom_clk_en falls. A request held for only IDLE_HOLD edges has no effect.
- R3: dom_iso rises GATE_TO_ISO cycles after dom_clk_en falls. dom_save rises ISO_TO_SAVE cycles after that, with an allowed window of 2 to 5 and a default of 2. dom_pwr_off rises SAVE_TO_OFF cycles after that, with an allowed window of 2 to 8 and a default of 2.
- R4: dom_pwr_off stays high for at least OFF_MIN cycles. It falls on edge max(rise + OFF_MIN, first edge at which a wake was sampled since entry began).
- R5: A wake pulse during entry is latched. Entry still reaches the off state, and power returns exactly OFF_MIN cycles after dom_pwr_off rose.
- R6: dom_rst_n falls SETTLE + RST_LEAD cycles after dom_pwr_off falls and stays low for RST_HOLD cycles. During that time the clock is gated, isolation is on and retention is held.
- R7: dom_save falls RESTORE_GAP cycles after dom_rst_n rises. dom_iso falls ISO_REL_GAP cycles after that. dom_clk_en rises CLK_REL_GAP cycles after that.
- R8: pstate is encoded as 0 for ON, 1 for ENTERING (from the clock-gate edge), 2 for OFF (from the power-off edge) and 3 for EXITING (from the power-on edge). It returns to 0 on the clock re-enable edge. busy is high exactly when pstate is not 0.
- R9: A wake pulse while ON is ignored. It does not shorten a later off period. After a return to ON, the idle count restarts from zero, so a held `sleep_req` re-enters IDLE_HOLD+1 cycles after clock re-enable.
- R10: Whenever dom_pwr_off is high, dom_iso and dom_save are high and dom_clk_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Controller reset, active low, asynchronous |
| sleep_req | input | 1 | Level request to shut the domain down |
| wake_req | input | 1 | Request to power the domain back up |
| dom_clk_en | output | 1 | Domain clock enable |
| dom_iso | output | 1 | Isolation enable for the domain outputs |
| dom_save | output | 1 | Retention level; high saves, falling edge restores |
| dom_pwr_off | output | 1 | Power-switch off command |
| dom_rst_n | output | 1 | Domain reset, active low |
| busy | output | 1 | High while a sequence is in progress |
| pstate | output | 2 | Power state code (see R8) |

## Verification
Every control output comes from a register loaded from the next state, so an edge that the requirements place N cycles after another shows up exactly N rising edges later. A request sampled on edge k affects the outputs no earlier than the values seen just after edge k. The bench drives requests on the falling edge and samples every output on the falling edge. It stamps each output transition with the count of rising edges seen so far. Each check then compares the difference between two stamps, or between a stamp and the edge at which a request was first sampled, with the gap its requirement states. The expected off-to-on time is computed as the larger of the minimum off time and the wake edge.

// File: rtl/pso_pkg.sv
package pso_pkg;

    typedef enum logic [3:0] {
        ST_ON       = 4'd0,
        ST_GATE     = 4'd1,
        ST_ISO      = 4'd2,
        ST_SAVE     = 4'd3,
        ST_OFF      = 4'd4,
        ST_SETTLE   = 4'd5,
        ST_RST_LEAD = 4'd6,
        ST_RST      = 4'd7,
        ST_RST_REL  = 4'd8,
        ST_UNSAVE   = 4'd9,
        ST_UNISO    = 4'd10
    } seq_st_t;

    typedef enum logic [1:0] {
        PS_ON    = 2'd0,
        PS_ENTER = 2'd1,
        PS_OFF   = 2'd2,
        PS_EXIT  = 2'd3
    } pwr_state_t;

    typedef struct packed {
        logic clk_en;
        logic iso;
        logic save;
        logic pwr_off;
        logic rst_n;
    } dom_ctl_t;

    localparam dom_ctl_t CTL_SAFE = '{clk_en: 1'b1, iso: 1'b0, save: 1'b0,
                                      pwr_off: 1'b0, rst_n: 1'b1};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Domain control levels held while the machine sits in a state
    function automatic dom_ctl_t ctl_of(input seq_st_t s);
        dom_ctl_t c;
        c = CTL_SAFE;
        case (s)
            ST_ON:       c = CTL_SAFE;
            ST_GATE:     begin c.clk_en = 1'b0; end
            ST_ISO:      begin c.clk_en = 1'b0; c.iso = 1'b1; end
            ST_SAVE:     begin c.clk_en = 1'b0; c.iso = 1'b1; c.save = 1'b1; end
            ST_OFF:      begin c.clk_en = 1'b0; c.iso = 1'b1; c.save = 1'b1;
                               c.pwr_off = 1'b1; end
            ST_SETTLE,
            ST_RST_LEAD,
            ST_RST_REL:  begin c.clk_en = 1'b0; c.iso = 1'b1; c.save = 1'b1; end
            ST_RST:      begin c.clk_en = 1'b0; c.iso = 1'b1; c.save = 1'b1;
                               c.rst_n = 1'b0; end
            ST_UNSAVE:   begin c.clk_en = 1'b0; c.iso = 1'b1; end
            ST_UNISO:    begin c.clk_en = 1'b0; end
            default:     c = CTL_SAFE;
        endcase
        return c;
    endfunction

    function automatic pwr_state_t phase_of(input seq_st_t s);
        pwr_state_t p;
        case (s)
            ST_ON:                   p = PS_ON;
            ST_GATE, ST_ISO, ST_SAVE: p = PS_ENTER;
            ST_OFF:                  p = PS_OFF;
            default:                 p = PS_EXIT;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pso_idle_gate.sv
module pso_idle_gate #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic armed,
    output logic ok
);
    localparam int CW = (HOLD < 1) ? 1 : $clog2(HOLD + 1);
    localparam logic [CW-1:0] CMAX = CW'(HOLD);

    logic [CW-1:0] run_cnt;

    // Consecutive sampled-high count; cleared whenever the domain is not ON
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!armed || !sleep_req) begin
            run_cnt <= '0;
        end else if (run_cnt != CMAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign ok = armed && sleep_req && (run_cnt == CMAX);

endmodule

// File: rtl/pso_gap_timer.sv
module pso_gap_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] age;

    // Cycles since the current state was entered, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (restart) begin
            age <= '0;
        end else if (age != {W{1'b1}}) begin
            age <= age + 1'b1;
        end
    end

    assign done = (age >= limit);

endmodule

// File: rtl/pso_sequencer.sv
module pso_sequencer
    import pso_pkg::*;
#(
    parameter int IDLE_HOLD   = 8,
    parameter int GATE_TO_ISO = 2,
    parameter int ISO_TO_SAVE = 2,
    parameter int SAVE_TO_OFF = 2,
    parameter int OFF_MIN     = 50,
    parameter int SETTLE      = 10,
    parameter int RST_LEAD    = 2,
    parameter int RST_HOLD    = 3,
    parameter int RESTORE_GAP = 2,
    parameter int ISO_REL_GAP = 2,
    parameter int CLK_REL_GAP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_req,
    output logic       dom_clk_en,
    output logic       dom_iso,
    output logic       dom_save,
    output logic       dom_pwr_off,
    output logic       dom_rst_n,
    output logic       busy,
    output logic [1:0] pstate
);
    localparam int GMAX = imax(imax(imax(GATE_TO_ISO, ISO_TO_SAVE), imax(SAVE_TO_OFF, OFF_MIN)),
                          imax(imax(imax(SETTLE, RST_LEAD), imax(RST_HOLD, RESTORE_GAP)),
                               imax(ISO_REL_GAP, CLK_REL_GAP)));
    localparam int TW   = (GMAX < 2) ? 1 : $clog2(GMAX);
    localparam int OW   = $clog2(OFF_MIN + 1);

    seq_st_t       state, state_nx;
    logic          idle_ok;
    logic          gap_done;
    logic [TW-1:0] gap_lim;
    logic          wake_pend;
    logic          in_flight;
    logic          leave_off;
    dom_ctl_t      ctl_nx;

    // Idle qualifier: blocks thrashing on short sleep requests
    pso_idle_gate #(.HOLD(IDLE_HOLD)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .armed     (state == ST_ON),
        .ok        (idle_ok)
    );

    // Per-state dwell length
    always_comb begin
        unique case (state)
            ST_GATE:     gap_lim = TW'(GATE_TO_ISO - 1);
            ST_ISO:      gap_lim = TW'(ISO_TO_SAVE - 1);
            ST_SAVE:     gap_lim = TW'(SAVE_TO_OFF - 1);
            ST_OFF:      gap_lim = TW'(OFF_MIN - 1);
            ST_SETTLE:   gap_lim = TW'(SETTLE - 1);
            ST_RST_LEAD: gap_lim = TW'(RST_LEAD - 1);
            ST_RST:      gap_lim = TW'(RST_HOLD - 1);
            ST_RST_REL:  gap_lim = TW'(RESTORE_GAP - 1);
            ST_UNSAVE:   gap_lim = TW'(ISO_REL_GAP - 1);
            ST_UNISO:    gap_lim = TW'(CLK_REL_GAP - 1);
            default:     gap_lim = '0;
        endcase
    end

    pso_gap_timer #(.W(TW)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_nx != state),
        .limit   (gap_lim),
        .done    (gap_done)
    );

    assign in_flight = (state == ST_GATE) || (state == ST_ISO) ||
                       (state == ST_SAVE) || (state == ST_OFF);
    assign leave_off = (state == ST_OFF) && gap_done && (wake_pend || wake_req);

    // Wake requests seen during entry or while off are held until exit starts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_pend <= 1'b0;
        end else if (leave_off) begin
            wake_pend <= 1'b0;
        end else if (wake_req && in_flight) begin
            wake_pend <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ON:       if (idle_ok)   state_nx = ST_GATE;
            ST_GATE:     if (gap_done)  state_nx = ST_ISO;
            ST_ISO:      if (gap_done)  state_nx = ST_SAVE;
            ST_SAVE:     if (gap_done)  state_nx = ST_OFF;
            ST_OFF:      if (leave_off) state_nx = ST_SETTLE;
            ST_SETTLE:   if (gap_done)  state_nx = ST_RST_LEAD;
            ST_RST_LEAD: if (gap_done)  state_nx = ST_RST;
            ST_RST:      if (gap_done)  state_nx = ST_RST_REL;
            ST_RST_REL:  if (gap_done)  state_nx = ST_UNSAVE;
            ST_UNSAVE:   if (gap_done)  state_nx = ST_UNISO;
            ST_UNISO:    if (gap_done)  state_nx = ST_ON;
            default:                    state_nx = ST_ON;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ON;
        else        state <= state_nx;
    end

    // Registered outputs, glitch free for the domain reset
    assign ctl_nx = ctl_of(state_nx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dom_clk_en  <= 1'b1;
            dom_iso     <= 1'b0;
            dom_save    <= 1'b0;
            dom_pwr_off <= 1'b0;
            dom_rst_n   <= 1'b1;
            busy        <= 1'b0;
            pstate      <= PS_ON;
        end else begin
            dom_clk_en  <= ctl_nx.clk_en;
            dom_iso     <= ctl_nx.iso;
            dom_save    <= ctl_nx.save;
            dom_pwr_off <= ctl_nx.pwr_off;
            dom_rst_n   <= ctl_nx.rst_n;
            busy        <= (state_nx != ST_ON);
            pstate      <= phase_of(state_nx);
        end
    end

    // Cycles the power switch has been open, for the off-time check
    logic [OW-1:0] off_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     off_age <= '0;
        else if (!dom_pwr_off)          off_age <= '0;
        else if (off_age != OW'(OFF_MIN)) off_age <= off_age + 1'b1;
    end

    // R2
    gate_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_clk_en) |-> $past(sleep_req));

    // R3
    save_after_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_save) |-> (dom_iso && !dom_clk_en));

    // R3
    off_after_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_pwr_off) |-> (dom_save && dom_iso));

    // R4
    min_off_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_pwr_off) |-> (off_age >= OW'(OFF_MIN)));

    // R5
    no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == PS_ENTER) |=> ((pstate == PS_ENTER) || (pstate == PS_OFF)));

    // R6
    rst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_rst_n |-> (!dom_pwr_off && dom_save && dom_iso && !dom_clk_en));

    // R7
    clk_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_clk_en) |-> (!dom_iso && !dom_save && dom_rst_n));

    // R8
    busy_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (pstate != PS_ON));

    // R10
    off_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dom_pwr_off |-> (dom_iso && dom_save && !dom_clk_en));

endmodule

// File: tb/pso_sequencer_tb.sv
`timescale 1ns/1ps
module pso_sequencer_tb;
    localparam int IDLE = 8, G_ISO = 2, G_SAVE = 2, G_OFF = 2, OFFMIN = 50;
    localparam int SETL = 10, LEAD = 2, HOLD = 3, RSTO = 2, ISOR = 2, CLKR = 2;

    logic clk = 1'b0, rst_n = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
    logic dom_clk_en, dom_iso, dom_save, dom_pwr_off, dom_rst_n, busy;
    logic [1:0] pstate;

    pso_sequencer #(
        .IDLE_HOLD(IDLE), .GATE_TO_ISO(G_ISO), .ISO_TO_SAVE(G_SAVE), .SAVE_TO_OFF(G_OFF),
        .OFF_MIN(OFFMIN), .SETTLE(SETL), .RST_LEAD(LEAD), .RST_HOLD(HOLD),
        .RESTORE_GAP(RSTO), .ISO_REL_GAP(ISOR), .CLK_REL_GAP(CLKR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .dom_clk_en(dom_clk_en), .dom_iso(dom_iso), .dom_save(dom_save),
        .dom_pwr_off(dom_pwr_off), .dom_rst_n(dom_rst_n), .busy(busy), .pstate(pstate)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    int inv_ps = 0, inv_busy = 0, inv_safe = 0;
    int t_cg_f = -1, t_cg_r = -1, t_iso_r = -1, t_iso_f = -1, t_sv_r = -1, t_sv_f = -1;
    int t_off_r = -1, t_off_f = -1, t_rst_f = -1, t_rst_r = -1;
    logic p_cg = 1'b1, p_iso = 1'b0, p_sv = 1'b0, p_off = 1'b0, p_rst = 1'b1;
    logic [1:0] ph = 2'd0;
    bit sleeping = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: stamps every output edge with the rising-edge count
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cg && !dom_clk_en)  begin t_cg_f = cyc; ph = 2'd1; end
            if (!p_cg && dom_clk_en)  begin t_cg_r = cyc; ph = 2'd0; end
            if (!p_iso && dom_iso)    t_iso_r = cyc;
            if (p_iso && !dom_iso)    t_iso_f = cyc;
            if (!p_sv && dom_save)    t_sv_r = cyc;
            if (p_sv && !dom_save)    t_sv_f = cyc;
            if (!p_off && dom_pwr_off) begin t_off_r = cyc; ph = 2'd2; end
            if (p_off && !dom_pwr_off) begin t_off_f = cyc; ph = 2'd3; end
            if (p_rst && !dom_rst_n)  t_rst_f = cyc;
            if (!p_rst && dom_rst_n)  t_rst_r = cyc;
            if (pstate != ph) inv_ps++;
            if (busy != (ph != 2'd0)) inv_busy++;
            if (dom_pwr_off && !(dom_iso && dom_save && !dom_clk_en)) inv_safe++;
            p_cg = dom_clk_en; p_iso = dom_iso; p_sv = dom_save;
            p_off = dom_pwr_off; p_rst = dom_rst_n;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // One full shut-off / wake cycle with timing checks
    task automatic run_seq(input bit early, input int wd, input bit keep);
        int exp_cg, t_wake, exp_fall;
        if (!sleeping) begin
            tick();
            sleep_req = 1'b1;
            sleeping = 1'b1;
            exp_cg = cyc + IDLE + 1;
        end else begin
            exp_cg = t_cg_r + IDLE + 1;
        end
        for (int i = 0; i < 300 && dom_clk_en; i++) tick();
        t_wake = 0;
        if (early) begin
            repeat (wd) tick();
            wake_req = 1'b1; t_wake = cyc + 1;
            tick();
            wake_req = 1'b0;
        end
        for (int i = 0; i < 300 && !dom_pwr_off; i++) tick();
        if (!keep) begin sleep_req = 1'b0; sleeping = 1'b0; end
        if (!early) begin
            repeat (wd) tick();
            wake_req = 1'b1; t_wake = cyc + 1;
            tick();
            wake_req = 1'b0;
        end
        for (int i = 0; i < 400 && busy; i++) tick();
        tick(); tick();
        chk(t_cg_f == exp_cg, "R2 entry edge", t_cg_f, exp_cg);
        chk(t_iso_r - t_cg_f == G_ISO, "R3 gate->iso", t_iso_r - t_cg_f, G_ISO);
        chk(t_sv_r - t_iso_r == G_SAVE, "R3 iso->save", t_sv_r - t_iso_r, G_SAVE);
        chk(t_off_r - t_sv_r == G_OFF, "R3 save->off", t_off_r - t_sv_r, G_OFF);
        exp_fall = maxi(t_off_r + OFFMIN, t_wake);
        chk(t_off_f == exp_fall, "R4 power-on edge", t_off_f, exp_fall);
        if (early)
            chk(t_off_f - t_off_r == OFFMIN, "R5 latched wake off time", t_off_f - t_off_r, OFFMIN);
        chk(t_rst_f - t_off_f == SETL + LEAD, "R6 reset lead", t_rst_f - t_off_f, SETL + LEAD);
        chk(t_rst_r - t_rst_f == HOLD, "R6 reset hold", t_rst_r - t_rst_f, HOLD);
        chk(t_sv_f - t_rst_r == RSTO, "R7 restore gap", t_sv_f - t_rst_r, RSTO);
        chk(t_iso_f - t_sv_f == ISOR, "R7 iso release gap", t_iso_f - t_sv_f, ISOR);
        chk(t_cg_r - t_iso_f == CLKR, "R7 clock release gap", t_cg_r - t_iso_f, CLKR);
    endtask

    always @(posedge clk) begin
        if (cyc == 100000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        // R1 reset state
        repeat (3) tick();
        chk({dom_clk_en, dom_iso, dom_save, dom_pwr_off, dom_rst_n} == 5'b10001,
            "R1 controls in reset", {dom_clk_en, dom_iso, dom_save, dom_pwr_off, dom_rst_n}, 5'b10001);
        rst_n = 1'b1;
        repeat (3) tick();
        chk({dom_clk_en, dom_iso, dom_save, dom_pwr_off, dom_rst_n} == 5'b10001,
            "R1 controls after reset", {dom_clk_en, dom_iso, dom_save, dom_pwr_off, dom_rst_n}, 5'b10001);
        chk(busy == 1'b0 && pstate == 2'd0, "R1 busy/pstate", {busy, pstate}, 0);

        // R2 request one edge too short
        sleep_req = 1'b1;
        repeat (IDLE) tick();
        sleep_req = 1'b0;
        repeat (20) tick();
        chk(dom_clk_en == 1'b1 && busy == 1'b0, "R2 short request ignored", {dom_clk_en, busy}, 2'b10);

        // R5 wake on the first entry cycle
        run_seq(1'b1, 0, 1'b0);
        // R9 wake while ON is not latched
        tick(); wake_req = 1'b1; tick(); wake_req = 1'b0;
        repeat (5) tick();
        chk(busy == 1'b0, "R9 wake in ON ignored", busy, 0);
        run_seq(1'b0, 60, 1'b0);
        chk(t_off_f - t_off_r == 61, "R9 off time follows later wake", t_off_f - t_off_r, 61);
        // R9 held sleep re-enters after idle count restarts
        run_seq(1'b0, 5, 1'b1);
        run_seq(1'b0, 0, 1'b0);
        // Random mix
        for (int k = 0; k < 6; k++) begin
            bit e, kp;
            int w;
            e  = ($urandom_range(0, 1) == 1);
            w  = e ? int'($urandom_range(0, 5)) : int'($urandom_range(0, 80));
            kp = ($urandom_range(0, 3) == 0);
            run_seq(e, w, kp);
        end
        if (sleeping) begin sleep_req = 1'b0; sleeping = 1'b0; end
        repeat (40) tick();
        chk(inv_ps == 0, "R8 pstate tracks edges", inv_ps, 0);
        chk(inv_busy == 0, "R8 busy matches pstate", inv_busy, 0);
        chk(inv_safe == 0, "R10 off implies safe controls", inv_safe, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule